// File: doc/BRIEF.md
# Single-Bit Elastic Buffer with Centred Start

This block retimes a serial bit stream from the clock domain of a capture front end into a free-running local clock of the same nominal rate. A bit is stored on every write-clock cycle in which the write strobe is high. One bit is taken out on every read-clock cycle in which the local bit-period tick is high. The two nominal rates are both 8 Mbps. The incoming rate may be up to 50 ppm faster or slower than the local one.

The read side waits until half of the storage holds data before it starts reading. This places the fill level in the middle of the buffer, so slow drift in either direction has DEPTH/2 bits of room before anything is lost. The write and read pointers cross between the domains as Gray-coded values, through a chain of synchronizer flops. When the buffer overflows or underflows, the block raises a one-cycle flag and goes back to waiting for half fill. It does not hand out wrong bits without marking them.

Top module: `elastic_bit_buffer`

## Requirements
- R1: While rst_ni is low, and after it is released, rd_bit_o, rd_valid_o, ovf_o and unf_o are 0.
- R2: Bits come out on rd_bit_o in the order in which they were accepted. No bit is repeated or lost, for a PRBS-23 stream (x^23+x^18+1) delivered at a write period that differs slightly from the read period.
- R3: After reset or a re-arm, the read side is idle. A tick on rd_tick_i while idle performs a read only if the synchronized fill is at least DEPTH/2 (32 for the default DEPTH of 64). Otherwise rd_bit_o and rd_valid_o are 0.
- R4: In each rclk cycle where a read takes place, rd_bit_o takes the next stored bit and rd_valid_o goes to 1. Both update at that rclk edge. Both hold their values in cycles without a tick.
- R5: A tick while reading with an empty buffer raises unf_o for exactly one rclk cycle. It drives rd_valid_o and rd_bit_o to 0 and returns the read side to idle, so half fill is needed again. Bits written afterwards are delivered without loss.
- R6: A strobe on wr_en_i while the buffer holds DEPTH bits raises ovf_o for exactly one wclk cycle. The incoming bit is discarded and the stored bits are unchanged.
- R7: An overflow re-arms the read side. Within a few rclk cycles, rd_valid_o and rd_bit_o go to 0 and stay there until the next tick that finds at least DEPTH/2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock from the capture front end |
| rclk_i | input | 1 | Stable local read clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_i | input | 1 | Write strobe, one bit per high cycle |
| wr_bit_i | input | 1 | Incoming data bit |
| rd_tick_i | input | 1 | Local bit-period tick, requests one read |
| rd_bit_o | output | 1 | Retimed data bit, 0 when not valid |
| rd_valid_o | output | 1 | rd_bit_o carries a stored bit |
| ovf_o | output | 1 | One-cycle overflow flag in the wclk domain |
| unf_o | output | 1 | One-cycle underflow flag in the rclk domain |

## Verification
The risky coincidence is a read tick arriving on an empty buffer in the same window as a write that the read side has not yet seen through its synchronizer. The bench provokes this by draining the buffer to empty. It then checks that the tick is reported as an underflow and that the bits written afterwards come out in order once half fill is reached again. The second coincidence is an overflow event and the re-arm of the read side. These fall in separate domains. The bench creates an overflow with reading stopped, checks that rd_valid_o drops without any tick, and then confirms that the 64 stored bits are read out intact without the discarded bit.

// File: rtl/ebuf_pkg.sv
`timescale 1ns/1ps
package ebuf_pkg;
  typedef enum logic {RD_IDLE = 1'b0, RD_RUN = 1'b1} rd_state_e;
endpackage

// File: rtl/ebuf_gray_sync.sv
`timescale 1ns/1ps
module ebuf_gray_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ebuf_wr_ctrl.sv
`timescale 1ns/1ps
module ebuf_wr_ctrl #(
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rptr_gray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_gray_o,
  output logic          ovf_o,
  output logic          ovf_tgl_o
);
  logic [AW:0] wbin, wbin_nxt;
  logic        full;

  // full: top two gray bits inverted, rest equal
  assign full     = (wptr_gray_o == {~rptr_gray_sync_i[AW:AW-1], rptr_gray_sync_i[AW-2:0]});
  assign we_o     = wr_en_i && !full;
  assign waddr_o  = wbin[AW-1:0];
  assign wbin_nxt = wbin + 1'b1;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin        <= '0;
      wptr_gray_o <= '0;
      ovf_o       <= 1'b0;
      ovf_tgl_o   <= 1'b0;
    end else begin
      ovf_o <= wr_en_i && full;
      if (wr_en_i && full) begin
        ovf_tgl_o <= ~ovf_tgl_o;
      end else if (wr_en_i) begin
        wbin        <= wbin_nxt;
        wptr_gray_o <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end
  end

  // R6
  full_hold_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_en_i && full |=> (wbin == $past(wbin)) && ovf_o);

  // R2
  wr_gray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wptr_gray_o ^ $past(wptr_gray_o)) <= 1);
endmodule

// File: rtl/ebuf_rd_ctrl.sv
`timescale 1ns/1ps
module ebuf_rd_ctrl
  import ebuf_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_tick_i,
  input  logic [AW:0]   wptr_gray_sync_i,
  input  logic          ovf_tgl_sync_i,
  input  logic          rd_bit_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rptr_gray_o,
  output logic          rd_bit_o,
  output logic          rd_valid_o,
  output logic          unf_o
);
  localparam logic [AW:0] HALF = (AW+1)'(1) << (AW-1);

  rd_state_e   state;
  logic [AW:0] rbin, rbin_nxt, wbin_sync, fill;
  logic        tgl_q, rearm, empty, half, do_read;

  always_comb begin
    wbin_sync[AW] = wptr_gray_sync_i[AW];
    for (int i = AW-1; i >= 0; i--) wbin_sync[i] = wbin_sync[i+1] ^ wptr_gray_sync_i[i];
  end

  assign fill     = wbin_sync - rbin;
  assign empty    = (fill == '0);
  assign half     = (fill >= HALF);
  assign rearm    = ovf_tgl_sync_i ^ tgl_q;
  assign do_read  = rd_tick_i && !empty && (state == RD_RUN || half);
  assign rbin_nxt = rbin + 1'b1;
  assign raddr_o  = rbin[AW-1:0];

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= RD_IDLE;
      rbin        <= '0;
      rptr_gray_o <= '0;
      rd_bit_o    <= 1'b0;
      rd_valid_o  <= 1'b0;
      unf_o       <= 1'b0;
      tgl_q       <= 1'b0;
    end else begin
      tgl_q <= ovf_tgl_sync_i;
      unf_o <= 1'b0;
      if (rearm) begin
        state      <= RD_IDLE;
        rd_bit_o   <= 1'b0;
        rd_valid_o <= 1'b0;
      end else if (do_read) begin
        state       <= RD_RUN;
        rd_bit_o    <= rd_bit_i;
        rd_valid_o  <= 1'b1;
        rbin        <= rbin_nxt;
        rptr_gray_o <= rbin_nxt ^ (rbin_nxt >> 1);
      end else if (rd_tick_i) begin
        if (state == RD_RUN) unf_o <= 1'b1;
        state      <= RD_IDLE;
        rd_bit_o   <= 1'b0;
        rd_valid_o <= 1'b0;
      end
    end
  end

  // R5
  unf_idle_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    unf_o |-> !rd_valid_o && !rd_bit_o);

  // R3
  start_half_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(fill) >= HALF);

  // R4
  hold_between_ticks_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !$past(rd_tick_i) && !$past(rearm) |-> $stable(rd_bit_o) && $stable(rd_valid_o));

  // R2
  rd_gray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rptr_gray_o ^ $past(rptr_gray_o)) <= 1);
endmodule

// File: rtl/elastic_bit_buffer.sv
`timescale 1ns/1ps
module elastic_bit_buffer #(
  parameter int DEPTH       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic rd_tick_i,
  output logic rd_bit_o,
  output logic rd_valid_o,
  output logic ovf_o,
  output logic unf_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    waddr, raddr;
  logic [AW:0]      wg, rg, wg_s, rg_s;
  logic             we, ovf_tgl, ovf_tgl_s;

  always_ff @(posedge wclk_i) begin
    if (we) mem[waddr] <= wr_bit_i;
  end

  ebuf_wr_ctrl #(.AW(AW)) u_wr (
    .wclk_i           (wclk_i),
    .rst_ni           (rst_ni),
    .wr_en_i          (wr_en_i),
    .rptr_gray_sync_i (rg_s),
    .we_o             (we),
    .waddr_o          (waddr),
    .wptr_gray_o      (wg),
    .ovf_o            (ovf_o),
    .ovf_tgl_o        (ovf_tgl)
  );

  ebuf_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (wg), .q_o (wg_s)
  );

  ebuf_gray_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (rg), .q_o (rg_s)
  );

  ebuf_gray_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf2r (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (ovf_tgl), .q_o (ovf_tgl_s)
  );

  ebuf_rd_ctrl #(.AW(AW)) u_rd (
    .rclk_i           (rclk_i),
    .rst_ni           (rst_ni),
    .rd_tick_i        (rd_tick_i),
    .wptr_gray_sync_i (wg_s),
    .ovf_tgl_sync_i   (ovf_tgl_s),
    .rd_bit_i         (mem[raddr]),
    .raddr_o          (raddr),
    .rptr_gray_o      (rg),
    .rd_bit_o         (rd_bit_o),
    .rd_valid_o       (rd_valid_o),
    .unf_o            (unf_o)
  );
endmodule

// File: tb/elastic_bit_buffer_test.sv
`timescale 1ns/1ps
module elastic_bit_buffer_test;
  localparam int DEPTH = 64;
  localparam int HALF  = DEPTH / 2;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_tick = 1'b0;
  logic rd_bit, rd_valid, ovf, unf;

  int          n_chk = 0, n_fail = 0;
  bit          exp_q[$];
  bit          model_run = 1'b0;
  bit          last_bit = 1'b0;
  bit          done = 1'b0;
  logic [22:0] lfsr = 23'h1;

  always #2.001 wclk = ~wclk;
  always #2     rclk = ~rclk;

  elastic_bit_buffer #(.DEPTH(DEPTH)) uut (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_n),
    .wr_en_i (wr_en), .wr_bit_i (wr_bit), .rd_tick_i (rd_tick),
    .rd_bit_o (rd_bit), .rd_valid_o (rd_valid), .ovf_o (ovf), .unf_o (unf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit prbs_next();
    bit nb = lfsr[22] ^ lfsr[17];
    lfsr = {lfsr[21:0], nb};
    return nb;
  endfunction

  task automatic write_bit(input bit b);
    bit full_exp = (exp_q.size() >= DEPTH);
    @(negedge wclk); wr_en = 1'b1; wr_bit = b;
    @(negedge wclk); wr_en = 1'b0;
    chk(ovf == full_exp, "R6 ovf_o on write", int'(ovf), int'(full_exp));
    if (!full_exp) exp_q.push_back(b);
    repeat (6) @(negedge wclk);
  endtask

  task automatic read_tick(input string req);
    bit ev, ed, eu;
    @(negedge rclk); rd_tick = 1'b1;
    @(negedge rclk); rd_tick = 1'b0;
    ev = 1'b0; ed = 1'b0; eu = 1'b0;
    if ((model_run || exp_q.size() >= HALF) && exp_q.size() > 0) begin
      ev = 1'b1; ed = exp_q.pop_front(); model_run = 1'b1;
    end else if (model_run) begin
      eu = 1'b1; model_run = 1'b0;
    end
    chk(rd_valid == ev, {req, " rd_valid_o"}, int'(rd_valid), int'(ev));
    chk(rd_bit == ed,   {req, " rd_bit_o"},   int'(rd_bit),   int'(ed));
    chk(unf == eu,      {req, " unf_o"},      int'(unf),      int'(eu));
    last_bit = ed;
    repeat (6) @(negedge rclk);
  endtask

  task automatic settle();
    repeat (10) @(negedge rclk);
  endtask

  task automatic test_reset();
    chk(rd_bit == 1'b0,   "R1 rd_bit_o",   int'(rd_bit),   0);
    chk(rd_valid == 1'b0, "R1 rd_valid_o", int'(rd_valid), 0);
    chk(ovf == 1'b0,      "R1 ovf_o",      int'(ovf),      0);
    chk(unf == 1'b0,      "R1 unf_o",      int'(unf),      0);
  endtask

  task automatic test_start();
    repeat (HALF - 1) write_bit(prbs_next());
    settle();
    repeat (3) read_tick("R3 below half");
    write_bit(prbs_next());
    settle();
    read_tick("R4 first read at half");
    repeat (3) @(negedge rclk);
    chk(rd_valid == 1'b1,     "R4 hold valid", int'(rd_valid), 1);
    chk(rd_bit == last_bit,   "R4 hold bit",   int'(rd_bit),   int'(last_bit));
  endtask

  task automatic test_stream();
    fork
      for (int i = 0; i < 600; i++) write_bit(prbs_next());
      for (int i = 0; i < 600; i++) read_tick("R2 stream");
    join
    settle();
  endtask

  task automatic test_underflow();
    while (exp_q.size() > 0) read_tick("R5 drain");
    read_tick("R5 tick on empty");
    chk(unf == 1'b0, "R5 unf_o one cycle", int'(unf), 0);
    repeat (5) write_bit(prbs_next());
    settle();
    read_tick("R5 re-armed below half");
    repeat (HALF - 5) write_bit(prbs_next());
    settle();
    read_tick("R5 resume no loss");
  endtask

  task automatic test_overflow();
    while (exp_q.size() < DEPTH) write_bit(prbs_next());
    settle();
    chk(rd_valid == 1'b1, "R7 valid before overflow", int'(rd_valid), 1);
    write_bit(prbs_next());
    @(negedge wclk);
    chk(ovf == 1'b0, "R6 ovf_o one cycle", int'(ovf), 0);
    settle();
    chk(rd_valid == 1'b0, "R7 re-arm valid", int'(rd_valid), 0);
    chk(rd_bit == 1'b0,   "R7 re-arm bit",   int'(rd_bit),   0);
    model_run = 1'b0;
    repeat (DEPTH) read_tick("R6 stored intact");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge rclk);
    test_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge rclk);
    test_reset();
    test_start();
    test_stream();
    test_underflow();
    test_overflow();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rclk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule